// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block drives a serial analog-to-digital converter that uses an active-low select, a serial address line, a host-generated I/O clock and a serial data return. A single request carries a 4-bit channel number. The sequencer lowers the select line, waits until the converter has qualified it, runs ten I/O clock pulses while shifting the address out MSB first and the previous conversion result in, then raises the select line and keeps it high for the full conversion time. A new request is only accepted after that time has passed.

The converter always returns the result of the conversion started by the previous access. For that reason the block keeps the channel of the prior request and tags each returned word with it. The first word after reset has no valid origin and is flagged as such. The I/O clock half period and the ratio of host clock to converter system clock are inputs. The ratio is given already rounded up to a whole number. Both waits are derived from that ratio in host clocks.

Top module: `serial_adc_sequencer`

## Requirements
- R1: While rst_ni is low and after its release with no request, cs_n_o is 1, ioclk_o is 0, addr_o is 0, busy_o is 0 and res_valid_o is 0. Reset acts asynchronously, also during a transfer.
- R2: A request (req_valid_i high at a rising clk_i edge) is accepted only while busy_o is 0. After acceptance, cs_n_o is 0 and busy_o is 1 from the next cycle on. Requests seen while busy_o is 1 are ignored: they neither lower cs_n_o nor change any later result tag.
- R3: The first ioclk_o rising edge follows the cs_n_o falling edge by exactly 3*R + H host clocks. R is the effective ratio and H the effective half period.
- R4: Each access has exactly 10 ioclk_o pulses. Each pulse is high for H host clocks and low for H host clocks, and ioclk_o is never high while cs_n_o is 1.
- R5: addr_o presents the channel MSB first, one bit per pulse, during the low phase before each of the first four rising edges, and holds it through the high phase. It is 0 for the remaining six pulses.
- R6: data_i is sampled in the last host clock before each ioclk_o rising edge. The ten samples, first one as MSB, form res_data_o.
- R7: res_valid_o is a one-cycle strobe in the cycle where cs_n_o returns to 1 after the tenth pulse. res_chan_o then carries the channel of the request before the current one, or 0 if there is none.
- R8: res_ok_o is 0 on the first result after reset and 1 on every later result.
- R9: After the strobe, cs_n_o stays 1 and busy_o stays 1 for exactly 44*R host clocks, after which busy_o falls.
- R10: A value of 0 on half_per_i or sys_ratio_i acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_per_i | input | 8 | I/O clock half period in host clocks (0 means 1) |
| sys_ratio_i | input | 8 | Host clocks per converter system clock, rounded up (0 means 1) |
| req_valid_i | input | 1 | Start request |
| req_chan_i | input | 4 | Channel to address |
| busy_o | output | 1 | Access or conversion wait in progress |
| cs_n_o | output | 1 | Converter select, active low |
| ioclk_o | output | 1 | Converter I/O clock |
| addr_o | output | 1 | Serial channel address |
| data_i | input | 1 | Serial result from converter |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 10 | Previous conversion result |
| res_chan_o | output | 4 | Channel the result belongs to |
| res_ok_o | output | 1 | Result has a real origin |

## Verification
A wrong state register or pulse counter shows up within one access as a pulse count other than ten, a shifted address that lands on the wrong channel in the next returned word, or a strobe that is not aligned with cs_n_o rising. A timer fault appears at once in the measured qualification gap, in the pulse high time or in the quiet window. A fault in the channel pipeline shows only one request later, as a wrong tag or a wrong res_ok_o. The bench therefore checks every result against the request before it, and runs back-to-back accesses with different settings.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_LOW,
    ST_HIGH,
    ST_CONV
  } sas_state_e;
endpackage

// File: rtl/sas_timer.sv
module sas_timer #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the loaded interval
  assign done_o = (cnt_q <= W'(1));
endmodule

// File: rtl/sas_capture.sv
module sas_capture #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign data_o = sh_q;
endmodule

// File: rtl/serial_adc_sequencer.sv
module serial_adc_sequencer #(
  parameter int RES_W    = 10,
  parameter int ADDR_W   = 4,
  parameter int DIV_W    = 8,
  parameter int RATIO_W  = 8,
  parameter int QUAL_SYS = 3,
  parameter int CONV_SYS = 44
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   half_per_i,
  input  logic [RATIO_W-1:0] sys_ratio_i,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_chan_i,
  output logic               busy_o,
  output logic               cs_n_o,
  output logic               ioclk_o,
  output logic               addr_o,
  input  logic               data_i,
  output logic               res_valid_o,
  output logic [RES_W-1:0]   res_data_o,
  output logic [ADDR_W-1:0]  res_chan_o,
  output logic               res_ok_o
);
  import sas_pkg::*;

  localparam int MULT_W = $clog2(CONV_SYS + 1);
  localparam int TMR_W  = (DIV_W > RATIO_W + MULT_W) ? DIV_W : RATIO_W + MULT_W;
  localparam int BIT_W  = $clog2(RES_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RES_W - 1);

  sas_state_e state_q, state_d;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] chan_q, tag_q, addr_sh_q;
  logic              have_q, ok_q;
  logic              accept, sample, finish, tmr_load, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic [TMR_W-1:0]  half_eff, ratio_eff, qual_len, conv_len;
  logic [RES_W-1:0]  cap_data;

  assign half_eff  = (half_per_i == '0)  ? TMR_W'(1) : TMR_W'(half_per_i);
  assign ratio_eff = (sys_ratio_i == '0) ? TMR_W'(1) : TMR_W'(sys_ratio_i);
  assign qual_len  = TMR_W'(QUAL_SYS) * ratio_eff;
  assign conv_len  = TMR_W'(CONV_SYS) * ratio_eff;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = half_eff;
    accept   = 1'b0;
    sample   = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = qual_len;
        state_d  = ST_QUAL;
      end
      ST_QUAL: if (tmr_done) begin
        tmr_load = 1'b1;
        state_d  = ST_LOW;
      end
      ST_LOW: if (tmr_done) begin
        tmr_load = 1'b1;
        sample   = 1'b1;
        state_d  = ST_HIGH;
      end
      ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        if (bit_q == LAST_BIT) begin
          finish  = 1'b1;
          tmr_val = conv_len;
          state_d = ST_CONV;
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_CONV: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      chan_q    <= '0;
      tag_q     <= '0;
      addr_sh_q <= '0;
      have_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tag_q     <= chan_q;   // result of this access belongs to the prior request
        ok_q      <= have_q;
        chan_q    <= req_chan_i;
        addr_sh_q <= req_chan_i;
        have_q    <= 1'b1;
        bit_q     <= '0;
      end else if (state_q == ST_HIGH && tmr_done) begin
        bit_q     <= bit_q + 1'b1;
        addr_sh_q <= addr_sh_q << 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
      res_ok_o    <= 1'b0;
    end else begin
      res_valid_o <= finish;
      if (finish) begin
        res_data_o <= cap_data;
        res_chan_o <= tag_q;
        res_ok_o   <= ok_q;
      end
    end
  end

  sas_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  sas_capture #(.W(RES_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sample),
    .bit_i   (data_i),
    .data_o  (cap_data)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign cs_n_o  = (state_q == ST_IDLE) || (state_q == ST_CONV);
  assign ioclk_o = (state_q == ST_HIGH);
  assign addr_o  = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && addr_sh_q[ADDR_W-1];
endmodule

// File: rtl/sas_checker.sv
module sas_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic cs_n_o,
  input logic ioclk_o,
  input logic addr_o,
  input logic res_valid_o
);
  assert_req_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> (busy_o && !cs_n_o));

  assert_no_clk_before_qual_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |=> !ioclk_o);

  assert_clk_inside_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ioclk_o |-> !cs_n_o);

  assert_addr_stable_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ioclk_o |-> $stable(addr_o));

  assert_strobe_at_cs_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $rose(cs_n_o));

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_quiet_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cs_n_o) |=> cs_n_o);

  assert_conv_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> busy_o);
endmodule

bind serial_adc_sequencer sas_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .cs_n_o      (cs_n_o),
  .ioclk_o     (ioclk_o),
  .addr_o      (addr_o),
  .res_valid_o (res_valid_o)
);

// File: tb/serial_adc_sequencer_tb.sv
`timescale 1ns/1ps
module serial_adc_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_per = 8'd1;
  logic [7:0] ratio = 8'd1;
  logic       req_valid = 1'b0;
  logic [3:0] req_chan = '0;
  logic       busy, cs_n, ioclk, addr, dout, res_valid, res_ok;
  logic [9:0] res_data;
  logic [3:0] res_chan;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_adc_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .half_per_i(half_per), .sys_ratio_i(ratio),
    .req_valid_i(req_valid), .req_chan_i(req_chan), .busy_o(busy),
    .cs_n_o(cs_n), .ioclk_o(ioclk), .addr_o(addr), .data_i(dout),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_chan_o(res_chan),
    .res_ok_o(res_ok)
  );

  // converter model: result of an access encodes its captured address
  function automatic logic [9:0] conv(input logic [3:0] a);
    return {a, ~a, 2'b10};
  endfunction

  logic [9:0] stored = 10'h3A5;
  logic [3:0] dev_addr = '0;
  int rises = 0, falls = 0;
  int t_csf = 0, t_rise = 0, t_fall1 = 0, t_csr = 0, t_bf = 0;
  initial dout = 1'b0;

  always @(negedge cs_n) begin
    rises = 0; falls = 0; dout = stored[9]; t_csf = cyc;
  end
  always @(posedge ioclk) begin
    if (rises < 4) dev_addr = {dev_addr[2:0], addr};
    rises++;
    if (rises == 1) t_rise = cyc;
  end
  always @(negedge ioclk) begin
    falls++;
    if (falls == 1) t_fall1 = cyc;
    if (falls < 10) dout = stored[9-falls];
    if (falls == 10) stored = conv(dev_addr);
  end
  always @(posedge cs_n) t_csr = cyc;
  always @(negedge busy) t_bf = cyc;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [3:0] prev_chan = '0;
  logic       have_prev = 1'b0;

  task automatic access(input logic [7:0] r, input logic [7:0] h, input logic [3:0] c);
    int re = (r == 0) ? 1 : int'(r);
    int he = (h == 0) ? 1 : int'(h);
    int n = 0;
    @(negedge clk);
    ratio = r; half_per = h; req_valid = 1'b1; req_chan = c;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 cs low after accept", int'(cs_n), 0);
    chk("R2 busy after accept", int'(busy), 1);
    while (!res_valid && n < 20000) begin @(negedge clk); n++; end
    chk("R7 strobe seen", int'(res_valid), 1);
    chk("R7 cs high at strobe", int'(cs_n), 1);
    chk("R8 ok flag", int'(res_ok), int'(have_prev));
    chk("R7 tag", int'(res_chan), int'(prev_chan));
    if (have_prev) chk("R6 R5 data", int'(res_data), int'(conv(prev_chan)));
    else           chk("R6 first data", int'(res_data), 10'h3A5);
    chk("R4 pulse count", rises, 10);
    chk("R3 qual gap", t_rise - t_csf, 3*re + he);
    chk("R4 high time", t_fall1 - t_rise, he);
    @(negedge clk);
    chk("R7 strobe one cycle", int'(res_valid), 0);
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk("R9 quiet window", t_bf - t_csr, 44*re);
    prev_chan = c; have_prev = 1'b1;
  endtask

  // {ratio, half, channel}
  localparam logic [19:0] VEC [6] = '{
    {8'd1, 8'd1, 4'h5}, {8'd2, 8'd1, 4'hA}, {8'd1, 8'd3, 4'h3},
    {8'd4, 8'd2, 4'hF}, {8'd3, 8'd1, 4'h0}, {8'd1, 8'd2, 4'h9}
  };

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs", int'(cs_n), 1);
    chk("R1 reset ioclk", int'(ioclk), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset strobe", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", int'(cs_n) + int'(busy) + int'(addr), 1);

    for (int i = 0; i < 6; i++) access(VEC[i][19:12], VEC[i][11:4], VEC[i][3:0]);

    // R10: zero settings act as one
    access(8'd0, 8'd0, 4'h2);

    // R2: request during conversion is ignored
    @(negedge clk);
    ratio = 8'd2; half_per = 8'd1; req_valid = 1'b1; req_chan = 4'h1;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int n = 0;
      while (!res_valid && n < 20000) begin @(negedge clk); n++; end
    end
    req_valid = 1'b1; req_chan = 4'h7;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy request ignored cs", int'(cs_n), 1);
    while (busy) @(negedge clk);
    prev_chan = 4'h1;
    access(8'd1, 8'd1, 4'hC);

    // R1 R8: reset in mid transfer, next result flagged invalid
    @(negedge clk);
    req_valid = 1'b1; req_chan = 4'h6;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset cs", int'(cs_n), 1);
    chk("R1 async reset ioclk", int'(ioclk), 0);
    chk("R1 async reset busy", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    have_prev = 1'b0; prev_chan = 4'h0;
    stored = 10'h3A5;
    access(8'd1, 8'd1, 4'h4);
    access(8'd2, 8'd2, 4'hB);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule